// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves byte channels between time-division multiplexed streams. Upstream logic has already turned each serial input into parallel bytes. Each byte reaches the block tagged with its stream and channel number. The block stores the byte in a data memory with three frame banks, used in rotation. One bank is written, one is held and one is read, so every byte leaves exactly two frames after it arrived, whatever its position in the frame. A connection table has one entry per output slot. Each entry names the source stream and channel and picks one of three behaviours: pass the switched byte, float the slot, or force the slot to all ones.

Downstream logic asks for an output slot by presenting a stream and channel. One cycle later the block returns the byte together with a drive-enable flag. Each stream has its own input rate code and its own output rate code, so streams running at different channel counts can exchange data. The table is programmed through a simple write port. Each write goes into a staging copy, and the staging copy is moved into the live table only at a frame boundary. An output slot therefore never mixes the old connection with the new one.

A one-cycle `frame_sync` pulse closes the current frame, and traffic from the next cycle belongs to the new frame. The first pulse after reset starts the bank rotation at bank zero. Input bytes offered before that first pulse are discarded.

Top module: `tsi_switch`

## Requirements
- R1: After reset every connection entry is in float mode, so every in-range request returns valid 1, enable 0 and data 0x00 until programmed entries are made live.
- R2: A byte accepted during frame f is returned for requests made during frame f+2 that select it. Frames are numbered from the first `frame_sync` after reset (frame 0). The response appears on the cycle after `out_req`.
- R3: Any output slot may select any input stream and channel, and one input slot may feed several output slots in the same frame.
- R4: Mode code 01 (float) returns valid 1, enable 0 and data 0x00.
- R5: Mode code 10 (force high) returns valid 1, enable 1 and data 0xFF.
- R6: Mode code 11 behaves exactly like 01. Mode code 00 selects switched data with enable 1.
- R7: A table write becomes visible only after the next `frame_sync`. A write presented in the same cycle as a `frame_sync` becomes visible only after the following one.
- R8: A stream's channel count is 2, 4, 8 or 16 for rate codes 0, 1, 2 or 3 (MAX_CH >> (3 - code)). Input bytes whose channel is at or above the count for their stream's input rate are ignored, and the stored byte for that slot is kept.
- R9: A request whose channel is at or above the count for that output stream's rate returns valid 0, enable 0 and data 0x00.
- R10: A switched entry whose source channel is at or above the count for the source stream's current input rate returns enable 1 and data 0x00.
- R11: With no request in the previous cycle, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse that closes the current frame |
| in_rate | input | 2*N_STREAMS | Input rate code per stream, stream s at bits [2s+1:2s] |
| out_rate | input | 2*N_STREAMS | Output rate code per stream, same layout |
| in_valid | input | 1 | An input byte is offered |
| in_stream | input | SW | Input byte stream |
| in_chan | input | CW | Input byte channel |
| in_data | input | 8 | Input byte |
| cm_we | input | 1 | Connection table write strobe |
| cm_ostream | input | SW | Output stream being programmed |
| cm_ochan | input | CW | Output channel being programmed |
| cm_mode | input | 2 | 00 switch, 01 float, 10 force high, 11 float |
| cm_sstream | input | SW | Source stream |
| cm_schan | input | CW | Source channel |
| out_req | input | 1 | Output slot request |
| out_stream | input | SW | Requested output stream |
| out_chan | input | CW | Requested output channel |
| out_valid | output | 1 | Response present (cycle after request) |
| out_oe | output | 1 | Drive enable for the slot |
| out_data | output | 8 | Slot byte |

## Verification
A wrong bank pointer shows as bytes from the wrong frame. It is caught in the third frame after the first sync, when the first switched reads are compared against the bytes sent two frames earlier. A live table that is updated too early shows up in the very next request after a mid-frame write. A table that is never updated shows up one frame later. Rate-window errors show in the same frame, either as a dropped response or as a stale byte surfacing once full rate is restored.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int N_STREAMS = 4,
  parameter int MAX_CH    = 16,
  parameter int SW        = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1,
  parameter int CW        = $clog2(MAX_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  input  logic [2*N_STREAMS-1:0] in_rate,
  input  logic [2*N_STREAMS-1:0] out_rate,
  input  logic                   in_valid,
  input  logic [SW-1:0]          in_stream,
  input  logic [CW-1:0]          in_chan,
  input  logic [7:0]             in_data,
  input  logic                   cm_we,
  input  logic [SW-1:0]          cm_ostream,
  input  logic [CW-1:0]          cm_ochan,
  input  logic [1:0]             cm_mode,
  input  logic [SW-1:0]          cm_sstream,
  input  logic [CW-1:0]          cm_schan,
  input  logic                   out_req,
  input  logic [SW-1:0]          out_stream,
  input  logic [CW-1:0]          out_chan,
  output logic                   out_valid,
  output logic                   out_oe,
  output logic [7:0]             out_data
);
  localparam int SLOTS = N_STREAMS * MAX_CH;
  localparam int DEPTH = 3 * SLOTS;
  localparam int AW    = $clog2(DEPTH);
  localparam int SAW   = $clog2(SLOTS);
  localparam int CMW   = 2 + SW + CW;
  localparam logic [1:0] M_SW = 2'b00, M_HIZ = 2'b01, M_HIGH = 2'b10;

  function automatic logic [CW:0] chan_count(input logic [1:0] code);
    chan_count = (CW+1)'(MAX_CH >> (3 - int'(code)));
  endfunction

  logic [1:0]     wr_bank, rd_bank;
  logic           started;
  logic [7:0]     mem     [DEPTH];
  logic [CMW-1:0] cm_next [SLOTS];
  logic [CMW-1:0] cm_live [SLOTS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_bank <= 2'd0;
      started <= 1'b0;
    end else if (frame_sync) begin
      started <= 1'b1;
      if (!started)            wr_bank <= 2'd0;
      else if (wr_bank == 2'd2) wr_bank <= 2'd0;
      else                      wr_bank <= wr_bank + 2'd1;
    end

  assign rd_bank = (wr_bank == 2'd2) ? 2'd0 : wr_bank + 2'd1;

  logic          in_ok;
  logic [AW-1:0] wr_idx;
  assign in_ok  = in_valid && started && (int'(in_stream) < N_STREAMS) &&
                  ({1'b0, in_chan} < chan_count(in_rate[in_stream*2 +: 2]));
  assign wr_idx = AW'(int'(wr_bank) * SLOTS + int'(in_stream) * MAX_CH + int'(in_chan));

  always_ff @(posedge clk)
    if (in_ok) mem[wr_idx] <= in_data;

  logic [SAW-1:0] cm_idx;
  assign cm_idx = SAW'(int'(cm_ostream) * MAX_CH + int'(cm_ochan));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        cm_next[i] <= {M_HIZ, {(SW+CW){1'b0}}};
        cm_live[i] <= {M_HIZ, {(SW+CW){1'b0}}};
      end
    end else begin
      if (frame_sync)
        for (int i = 0; i < SLOTS; i++) cm_live[i] <= cm_next[i];
      if (cm_we && int'(cm_ostream) < N_STREAMS)
        cm_next[cm_idx] <= {cm_mode, cm_sstream, cm_schan};
    end

  logic [SAW-1:0] req_idx;
  logic [CMW-1:0] entry;
  logic [1:0]     e_mode;
  logic [SW-1:0]  e_ss;
  logic [CW-1:0]  e_sc;
  logic           req_ok, src_ok, drive;
  logic [AW-1:0]  rd_idx;
  logic [7:0]     slot_byte;

  assign req_idx = SAW'(int'(out_stream) * MAX_CH + int'(out_chan));
  assign entry   = cm_live[req_idx];
  assign {e_mode, e_ss, e_sc} = entry;
  assign req_ok  = out_req && (int'(out_stream) < N_STREAMS) &&
                   ({1'b0, out_chan} < chan_count(out_rate[out_stream*2 +: 2]));
  assign src_ok  = (int'(e_ss) < N_STREAMS) &&
                   ({1'b0, e_sc} < chan_count(in_rate[e_ss*2 +: 2]));
  assign rd_idx  = AW'(int'(rd_bank) * SLOTS + int'(e_ss) * MAX_CH + int'(e_sc));
  assign drive   = (e_mode == M_SW) || (e_mode == M_HIGH);
  assign slot_byte = (e_mode == M_HIGH)           ? 8'hFF :
                     (e_mode == M_SW && src_ok)   ? mem[rd_idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_oe    <= 1'b0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= req_ok;
      out_oe    <= req_ok && drive;
      out_data  <= req_ok ? slot_byte : 8'h00;
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int N_STREAMS = 4,
  parameter int MAX_CH    = 16,
  parameter int SW        = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1,
  parameter int CW        = $clog2(MAX_CH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*N_STREAMS-1:0] out_rate,
  input logic                   out_req,
  input logic [SW-1:0]          out_stream,
  input logic [CW-1:0]          out_chan,
  input logic                   out_valid,
  input logic                   out_oe,
  input logic [7:0]             out_data
);
  function automatic int lim(input logic [1:0] code);
    lim = MAX_CH >> (3 - int'(code));
  endfunction

  assert_resp_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_req));

  assert_float_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oe) |-> (out_data == 8'h00));

  assert_oe_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_oe |-> out_valid);

  assert_out_range_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && int'(out_chan) >= lim(out_rate[out_stream*2 +: 2])) |=> !out_valid);
endmodule

bind tsi_switch tsi_switch_chk #(.N_STREAMS(N_STREAMS), .MAX_CH(MAX_CH), .SW(SW), .CW(CW)) u_chk (.*);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int MC = 16;

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0;
  logic [2*NS-1:0] in_rate, out_rate;
  logic in_valid = 1'b0, cm_we = 1'b0, out_req = 1'b0;
  logic [1:0] in_stream = '0, cm_ostream = '0, cm_sstream = '0, out_stream = '0;
  logic [3:0] in_chan = '0, cm_ochan = '0, cm_schan = '0, out_chan = '0;
  logic [7:0] in_data = '0;
  logic [1:0] cm_mode = '0;
  logic out_valid, out_oe;
  logic [7:0] out_data;

  int irate [NS];
  int orate [NS];
  logic [7:0] cm_sh [NS*MC];
  logic [7:0] cm_act [NS*MC];
  logic [7:0] hist [3][NS][MC];
  bit known [3][NS][MC];
  int fr = -1;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int s = 0; s < NS; s++) begin
      in_rate[s*2 +: 2]  = 2'(irate[s]);
      out_rate[s*2 +: 2] = 2'(orate[s]);
    end

  tsi_switch #(.N_STREAMS(NS), .MAX_CH(MC)) u0 (.*);

  function automatic int cnt(input int code);
    return MC >> (3 - code);
  endfunction

  function automatic logic [7:0] val(input int f, input int s, input int c);
    return 8'(f * 37 + s * 16 + c + 1);
  endfunction

  task automatic sync_pulse(input bit wr, input int ds, input int dc, input logic [7:0] e);
    @(negedge clk);
    frame_sync = 1'b1;
    if (wr) begin
      cm_we = 1'b1; cm_ostream = 2'(ds); cm_ochan = 4'(dc);
      {cm_mode, cm_sstream, cm_schan} = e;
    end
    @(negedge clk);
    frame_sync = 1'b0; cm_we = 1'b0;
    for (int i = 0; i < NS*MC; i++) cm_act[i] = cm_sh[i];
    if (wr) cm_sh[ds*MC+dc] = e;
    fr++;
  endtask

  task automatic cm_wr(input int ds, input int dc, input logic [7:0] e);
    @(negedge clk);
    cm_we = 1'b1; cm_ostream = 2'(ds); cm_ochan = 4'(dc);
    {cm_mode, cm_sstream, cm_schan} = e;
    @(negedge clk);
    cm_we = 1'b0;
    cm_sh[ds*MC+dc] = e;
  endtask

  task automatic send_all();
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < MC; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_stream = 2'(s); in_chan = 4'(c); in_data = val(fr, s, c);
        if (fr >= 0 && c < cnt(irate[s])) begin
          hist[fr%3][s][c] = val(fr, s, c);
          known[fr%3][s][c] = 1'b1;
        end
      end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_dest(input int s, input int c, input string ctx);
    logic ev, eo; logic [7:0] ed; bit dchk; string tag;
    logic [7:0] e; int ss, sc, rb;
    @(negedge clk);
    out_req = 1'b1; out_stream = 2'(s); out_chan = 4'(c);
    @(negedge clk);
    out_req = 1'b0;
    dchk = 1'b1;
    if (c >= cnt(orate[s])) begin
      ev = 0; eo = 0; ed = 8'h00; tag = "R9";
    end else begin
      e = cm_act[s*MC+c]; ev = 1;
      case (e[7:6])
        2'b01: begin eo = 0; ed = 8'h00; tag = "R4"; end
        2'b11: begin eo = 0; ed = 8'h00; tag = "R6"; end
        2'b10: begin eo = 1; ed = 8'hFF; tag = "R5"; end
        default: begin
          eo = 1; ss = int'(e[5:4]); sc = int'(e[3:0]);
          if (sc >= cnt(irate[ss])) begin
            ed = 8'h00; tag = "R10";
          end else begin
            tag = "R2 R3";
            rb = (fr + 1) % 3;
            if (fr >= 0 && known[rb][ss][sc]) ed = hist[rb][ss][sc];
            else begin ed = 8'h00; dchk = 1'b0; end
          end
        end
      endcase
    end
    checks++;
    if (out_valid !== ev || out_oe !== eo || (dchk && out_data !== ed)) begin
      fails++;
      $display("FAIL %s %s slot %0d/%0d: got v=%b oe=%b d=%h expected v=%b oe=%b d=%h",
               ctx, tag, s, c, out_valid, out_oe, out_data, ev, eo, ed);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < MC; c++) check_dest(s, c, ctx);
  endtask

  task automatic frame(input string ctx);
    sync_pulse(1'b0, 0, 0, 8'h00);
    send_all();
    check_all(ctx);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin irate[s] = 3; orate[s] = 3; end
    for (int i = 0; i < NS*MC; i++) begin cm_sh[i] = 8'h40; cm_act[i] = 8'h40; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R11 idle valid got %b expected 0", out_valid); end
    check_all("R1");

    for (int s = 0; s < NS; s++)
      for (int c = 0; c < MC; c++) begin
        int d;
        d = s*MC + c;
        if (d == 7)           cm_wr(s, c, 8'h40);
        else if (d == 9)      cm_wr(s, c, 8'hC0);
        else if (d % 11 == 5) cm_wr(s, c, 8'h80);
        else if (d == 1 || d == 32 || d == 48) cm_wr(s, c, {2'b00, 2'd1, 4'd4});
        else cm_wr(s, c, {2'b00, 2'((s+1)%4), 4'((c*3+s)%16)});
      end
    check_all("R7 staged");

    for (int k = 0; k < 5; k++) frame("R2 main");

    sync_pulse(1'b0, 0, 0, 8'h00);
    send_all();
    cm_wr(0, 3, 8'h80);
    check_dest(0, 3, "R7 mid-frame");
    sync_pulse(1'b1, 0, 3, {2'b00, 2'd2, 4'd9});
    send_all();
    check_dest(0, 3, "R7 sync-write");
    frame("R7 after");

    irate[1] = 0; irate[0] = 2; orate[2] = 1; orate[3] = 0;
    for (int k = 0; k < 3; k++) frame("R8 R9 R10");
    irate[1] = 3; irate[0] = 3; orate[2] = 3; orate[3] = 3;
    for (int k = 0; k < 3; k++) frame("R8 restored");

    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R11 idle valid got %b expected 0", out_valid); end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule